// File: doc/BRIEF.md
# Reset Source Sequencer

This block merges four independent reasons to reset a processor into one system reset line: the supply becoming good, a qualified low level on the external reset pin, a watchdog that was not serviced in time, and a clock monitor that notices the bus clock has stopped. Each source is conditioned before it reaches the output. Power-up is followed by a fixed stabilisation hold. Short pin glitches are filtered out. Pin and internal resets are stretched so that every reset lasts long enough for the rest of the chip.

Alongside the reset line the block reports which source caused the most recent reset. It provides the address from which the processor fetches its start vector, and it gives a one-cycle pulse telling the processor to load its program counter from that address. It also holds three processor mask flags (stop-disable, non-maskable-interrupt mask, maskable-interrupt mask). Every reset sets all three flags, and software may only clear them.

The watchdog counts bus-clock cycles. The clock monitor runs from a separate check clock and flags the bus clock as missing when no bus-clock activity reaches it within a set number of check-clock cycles. The check clock must run faster than the bus clock. A power-good input stands in for analog supply detection and acts as the block's asynchronous power-on reset.

Top module: `rst_source_seq`

## Requirements
- R1: After `powerGood` rises, `rstOut` stays high for exactly `PorCycles` (default 4064) bus-clock cycles and then falls. At release, `causeCode` is 0 and `vecAddr` is 0xFFFE.
- R2: A low on `pinRstN` lasting 5 or fewer consecutive bus-clock samples causes no reset. A low lasting `PinQualCycles` (default 6) samples or more does cause a reset with `causeCode` 0. That reset stays asserted while the pin is low and is released exactly 18 cycles after the pin returns high (2 synchroniser stages plus `StretchCycles` = 16).
- R3: While `wdEnable` is 1, the watchdog fires a reset with `causeCode` 2 and `vecAddr` 0xFFFA. It fires exactly N cycles after the last cycle in which `wdService` was sampled high, where N = 2^`WdDivLog2` times 1, 2 or 4 for `wdScale` = 00, 01 or 1x respectively.
- R4: A `wdService` strobe restarts the watchdog count, so services spaced less than N cycles apart never cause a reset.
- R5: While `wdEnable` is 0, the watchdog never causes a reset.
- R6: With `cmEnable` at 1, stopping the bus clock drives `rstOut` high within a few check-clock cycles, even though no bus-clock edge arrives. Once the bus clock resumes, the reset is released with `causeCode` 1 and `vecAddr` 0xFFFC. With `cmEnable` at 0, a stopped bus clock causes no reset.
- R7: `statusFlags` (bit 2 stop-disable, bit 1 non-maskable mask, bit 0 maskable mask) reads 3'b111 during and immediately after any reset. Outside reset, each 1 bit in `clrFlags` clears the matching flag one cycle later. `clrFlags` never sets a flag and has no effect while reset is asserted.
- R8: `fetchStart` is high for exactly one cycle: the first cycle in which `rstOut` is low after a reset. `vecAddr` then equals 0xFFFE minus twice `causeCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| chkClk | input | 1 | Independent check clock for the clock monitor |
| powerGood | input | 1 | Supply good; low acts as asynchronous power-on reset |
| pinRstN | input | 1 | External reset pin, active low, asynchronous |
| wdEnable | input | 1 | Watchdog enable |
| wdScale | input | 2 | Watchdog timeout scaler: 00 x1, 01 x2, 1x x4 |
| wdService | input | 1 | Watchdog service strobe |
| cmEnable | input | 1 | Clock monitor enable |
| clrFlags | input | 3 | Per-bit clear strobes for statusFlags |
| rstOut | output | 1 | System reset, active high |
| causeCode | output | 2 | 0 power-on/pin, 1 clock monitor, 2 watchdog |
| vecAddr | output | 16 | Start vector address for the current cause |
| fetchStart | output | 1 | One-cycle pulse at reset release |
| statusFlags | output | 3 | Stop-disable, non-maskable mask, maskable mask |

## Verification
The power-on release is due on the `PorCycles`-th bus edge after `powerGood` rises, and a watchdog reset is due on the N-th edge after the service edge. For both, the bench counts edges from the stimulus and samples on the falling edge just before and just after the due edge. The pin reset passes two synchroniser stages and a six-sample filter before it appears, and it is released 18 edges after the pin goes high. The bench therefore checks that the reset is present four edges after the pulse and that the release arrives exactly 18 edges after the pin rises. The clock-monitor reset cannot be counted in bus cycles, so it is checked after a fixed time with the bus clock stopped. Its cause is read at the release edge once the clock runs again.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    SEQ_POR  = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_RUN  = 2'd2
  } seqState_t;

  typedef enum logic [1:0] {
    CAUSE_PIN    = 2'd0,
    CAUSE_CLKMON = 2'd1,
    CAUSE_WDOG   = 2'd2
  } cause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdClr;
    logic holdCount;
    logic wdRun;
  } ctlStrobe_t;

endpackage

// File: rtl/rstseq_clkmon.sv
module rstseq_clkmon #(
  parameter int CmLimit = 8
) (
  input  logic chkClk,
  input  logic rstN,
  input  logic cmEnable,
  input  logic busTog,
  input  logic busAck,
  output logic cmFault
);
  localparam int CntW = $clog2(CmLimit) + 1;
  localparam logic [CntW-1:0] CntLast = CntW'(CmLimit - 1);

  logic [2:0]      togSync;
  logic [1:0]      ackSync;
  logic [CntW-1:0] missCnt;
  logic            edgeSeen;

  assign edgeSeen = togSync[2] ^ togSync[1];

  always_ff @(posedge chkClk or negedge rstN) begin
    if (!rstN) begin
      togSync <= '0;
      ackSync <= '0;
      missCnt <= '0;
      cmFault <= 1'b0;
    end else begin
      togSync <= {togSync[1:0], busTog};
      ackSync <= {ackSync[0], busAck};
      if (edgeSeen)
        missCnt <= '0;
      else if (missCnt != CntLast)
        missCnt <= missCnt + 1'b1;
      if (cmFault) begin
        // clear only once the bus side has seen the fault and runs again
        if (edgeSeen && ackSync[1]) cmFault <= 1'b0;
      end else if (cmEnable && !edgeSeen && missCnt == CntLast) begin
        cmFault <= 1'b1;
      end
    end
  end

  assert_cm_sticky_R6: assert property (@(posedge chkClk) disable iff (!rstN)
    (cmFault && !ackSync[1]) |=> cmFault);

  assert_cm_off_R6: assert property (@(posedge chkClk) disable iff (!rstN)
    (!cmEnable && !cmFault) |=> !cmFault);

endmodule

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int PorCycles     = 4064,
  parameter int StretchCycles = 16,
  parameter int PinQualCycles = 6,
  parameter int WdDivLog2     = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strb,
  input  logic       pinRstN,
  input  logic       wdEnable,
  input  logic [1:0] wdScale,
  input  logic       wdService,
  input  logic       cmFault,
  output logic       busTog,
  output logic       cmSeen,
  output logic       pinLow,
  output logic       pinQual,
  output logic       holdAtPor,
  output logic       holdAtStretch,
  output logic       wdExpire
);
  localparam int HoldMax = (PorCycles > StretchCycles) ? PorCycles : StretchCycles;
  localparam int HoldW   = $clog2(HoldMax) + 1;
  localparam int QualW   = $clog2(PinQualCycles) + 1;
  localparam int WdW     = WdDivLog2 + 3;

  localparam logic [HoldW-1:0] PorLast     = HoldW'(PorCycles - 1);
  localparam logic [HoldW-1:0] StretchLast = HoldW'(StretchCycles - 1);
  localparam logic [QualW-1:0] QualLast    = QualW'(PinQualCycles - 1);
  localparam logic [WdW-1:0]   WdLast1     = WdW'((1 << WdDivLog2) - 1);
  localparam logic [WdW-1:0]   WdLast2     = WdW'((1 << (WdDivLog2 + 1)) - 1);
  localparam logic [WdW-1:0]   WdLast4     = WdW'((1 << (WdDivLog2 + 2)) - 1);

  logic [1:0]       pinSync;
  logic [1:0]       cmSync;
  logic [HoldW-1:0] holdCnt;
  logic [QualW-1:0] qualCnt;
  logic [WdW-1:0]   wdCnt;
  logic [WdW-1:0]   wdLast;

  assign pinLow        = pinSync[1];
  assign cmSeen        = cmSync[1];
  assign pinQual       = pinLow && (qualCnt == QualLast);
  assign holdAtPor     = (holdCnt == PorLast);
  assign holdAtStretch = (holdCnt == StretchLast);

  always_comb begin
    case (wdScale)
      2'b00:   wdLast = WdLast1;
      2'b01:   wdLast = WdLast2;
      default: wdLast = WdLast4;
    endcase
  end

  // >= so that lowering the scaler mid-count still expires
  assign wdExpire = strb.wdRun && wdEnable && (wdCnt >= wdLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync <= '0;
      cmSync  <= '0;
      busTog  <= 1'b0;
      holdCnt <= '0;
      qualCnt <= '0;
      wdCnt   <= '0;
    end else begin
      pinSync <= {pinSync[0], ~pinRstN};
      cmSync  <= {cmSync[0], cmFault};
      busTog  <= ~busTog;

      if (strb.holdClr)        holdCnt <= '0;
      else if (strb.holdCount) holdCnt <= holdCnt + 1'b1;

      if (!pinLow)                qualCnt <= '0;
      else if (qualCnt != QualLast) qualCnt <= qualCnt + 1'b1;

      if (!strb.wdRun || !wdEnable || wdService) wdCnt <= '0;
      else if (wdCnt != '1)                       wdCnt <= wdCnt + 1'b1;
    end
  end

  assert_wd_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    wdService |=> !wdExpire);

  assert_wd_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdEnable) |=> (wdCnt == '0));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmSeen,
  input  logic       pinLow,
  input  logic       pinQual,
  input  logic       holdAtPor,
  input  logic       holdAtStretch,
  input  logic       wdExpire,
  input  logic [2:0] clrFlags,
  output ctlStrobe_t strb,
  output logic       rstBus,
  output logic [1:0] causeCode,
  output logic       fetchStart,
  output logic [2:0] statusFlags
);
  seqState_t state, nextState;
  cause_t    cause, nextCause;

  always_comb begin
    nextState = state;
    nextCause = cause;
    case (state)
      SEQ_POR: begin
        if (holdAtPor) nextState = SEQ_RUN;
      end
      SEQ_HOLD: begin
        if (holdAtStretch && !pinLow && !cmSeen) nextState = SEQ_RUN;
      end
      default: begin
        // clock monitor outranks watchdog, watchdog outranks the pin
        if (cmSeen) begin
          nextState = SEQ_HOLD;
          nextCause = CAUSE_CLKMON;
        end else if (wdExpire) begin
          nextState = SEQ_HOLD;
          nextCause = CAUSE_WDOG;
        end else if (pinQual) begin
          nextState = SEQ_HOLD;
          nextCause = CAUSE_PIN;
        end
      end
    endcase
  end

  always_comb begin
    strb.holdClr   = (state == SEQ_RUN) || (state == SEQ_HOLD && pinLow);
    strb.holdCount = (state == SEQ_POR && !holdAtPor) ||
                     (state == SEQ_HOLD && !holdAtStretch);
    strb.wdRun     = (state == SEQ_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= SEQ_POR;
      cause       <= CAUSE_PIN;
      fetchStart  <= 1'b0;
      statusFlags <= 3'b111;
    end else begin
      state      <= nextState;
      cause      <= nextCause;
      fetchStart <= (state != SEQ_RUN) && (nextState == SEQ_RUN);
      if (state != SEQ_RUN) statusFlags <= 3'b111;
      else                  statusFlags <= statusFlags & ~clrFlags;
    end
  end

  assign rstBus    = (state != SEQ_RUN);
  assign causeCode = cause;

  assert_cm_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_RUN && cmSeen) |=> (rstBus && causeCode == 2'd1));

  assert_wd_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_RUN && wdExpire && !cmSeen) |=> (rstBus && causeCode == 2'd2));

  assert_pin_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_RUN && pinQual && !wdExpire && !cmSeen) |=> (rstBus && causeCode == 2'd0));

  assert_fetch_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |=> !fetchStart);

  assert_fetch_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |-> (!rstBus && $past(rstBus)));

  assert_flags_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |-> (statusFlags == 3'b111));

endmodule

// File: rtl/rst_source_seq.sv
module rst_source_seq
  import rstseq_pkg::*;
#(
  parameter int          PorCycles     = 4064,
  parameter int          StretchCycles = 16,
  parameter int          PinQualCycles = 6,
  parameter int          WdDivLog2     = 15,
  parameter int          CmLimit       = 8,
  parameter logic [15:0] VecTop        = 16'hFFFE
) (
  input  logic        clk,
  input  logic        chkClk,
  input  logic        powerGood,
  input  logic        pinRstN,
  input  logic        wdEnable,
  input  logic [1:0]  wdScale,
  input  logic        wdService,
  input  logic        cmEnable,
  input  logic [2:0]  clrFlags,
  output logic        rstOut,
  output logic [1:0]  causeCode,
  output logic [15:0] vecAddr,
  output logic        fetchStart,
  output logic [2:0]  statusFlags
);
  ctlStrobe_t strb;
  logic busTog, cmSeen, cmFault, pinLow, pinQual;
  logic holdAtPor, holdAtStretch, wdExpire, rstBus;

  rstseq_datapath #(
    .PorCycles(PorCycles), .StretchCycles(StretchCycles),
    .PinQualCycles(PinQualCycles), .WdDivLog2(WdDivLog2)
  ) uData (
    .clk(clk), .rstN(powerGood), .strb(strb), .pinRstN(pinRstN),
    .wdEnable(wdEnable), .wdScale(wdScale), .wdService(wdService),
    .cmFault(cmFault), .busTog(busTog), .cmSeen(cmSeen), .pinLow(pinLow),
    .pinQual(pinQual), .holdAtPor(holdAtPor), .holdAtStretch(holdAtStretch),
    .wdExpire(wdExpire)
  );

  rstseq_ctrl uCtrl (
    .clk(clk), .rstN(powerGood), .cmSeen(cmSeen), .pinLow(pinLow),
    .pinQual(pinQual), .holdAtPor(holdAtPor), .holdAtStretch(holdAtStretch),
    .wdExpire(wdExpire), .clrFlags(clrFlags), .strb(strb), .rstBus(rstBus),
    .causeCode(causeCode), .fetchStart(fetchStart), .statusFlags(statusFlags)
  );

  rstseq_clkmon #(.CmLimit(CmLimit)) uMon (
    .chkClk(chkClk), .rstN(powerGood), .cmEnable(cmEnable),
    .busTog(busTog), .busAck(cmSeen), .cmFault(cmFault)
  );

  // the monitor path must not wait for a bus-clock edge
  assign rstOut  = rstBus | cmFault;
  assign vecAddr = VecTop - {13'd0, causeCode, 1'b0};

endmodule

// File: tb/tb_rst_source_seq.sv
`timescale 1ns/100ps
module tb_rst_source_seq;
  localparam int  ClkPeriod = 10;
  localparam real ChkHalf   = 3.5;
  localparam int  PorCyc    = 4064;
  localparam int  DivLog2   = 6;

  logic clk = 1'b0, chkClk = 1'b0, clkRun = 1'b1;
  logic powerGood, pinRstN, wdEnable, wdService, cmEnable;
  logic [1:0] wdScale;
  logic [2:0] clrFlags;
  logic rstOut, fetchStart;
  logic [1:0] causeCode;
  logic [15:0] vecAddr;
  logic [2:0] statusFlags;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #(ClkPeriod / 2) if (clkRun) clk = ~clk;
  always #(ChkHalf) chkClk = ~chkClk;

  rst_source_seq #(.PorCycles(PorCyc), .WdDivLog2(DivLog2)) dut (
    .clk(clk), .chkClk(chkClk), .powerGood(powerGood), .pinRstN(pinRstN),
    .wdEnable(wdEnable), .wdScale(wdScale), .wdService(wdService),
    .cmEnable(cmEnable), .clrFlags(clrFlags), .rstOut(rstOut),
    .causeCode(causeCode), .vecAddr(vecAddr), .fetchStart(fetchStart),
    .statusFlags(statusFlags)
  );

  function automatic int wdLimit(input int sc);
    return (1 << DivLog2) * ((sc == 0) ? 1 : (sc == 1) ? 2 : 4);
  endfunction

  function automatic logic [15:0] vecFor(input int cause);
    return 16'(32'hFFFE - 2 * cause);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitRelease(output int n);
    n = 0;
    while (rstOut === 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pinPulse(input int len);
    @(negedge clk) pinRstN = 1'b0;
    repeat (len) @(negedge clk);
    pinRstN = 1'b1;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(ClkPeriod * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [2:0] expFlags;
    powerGood = 0; pinRstN = 1; wdEnable = 0; wdService = 0;
    cmEnable = 0; wdScale = 0; clrFlags = 0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 reset state rstOut", 32'(rstOut), 1);
    check("R7 reset state flags", 32'(statusFlags), 3'b111);

    // R1 power-on hold
    powerGood = 1;
    repeat (PorCyc - 1) @(negedge clk);
    check("R1 held at last POR cycle", 32'(rstOut), 1);
    @(negedge clk);
    check("R1 released", 32'(rstOut), 0);
    check("R8 fetchStart at POR release", 32'(fetchStart), 1);
    check("R1 cause", 32'(causeCode), 0);
    check("R1 vector", 32'(vecAddr), 32'(vecFor(0)));
    @(negedge clk);
    check("R8 fetchStart single cycle", 32'(fetchStart), 0);

    // R7 flag clearing with random masks
    expFlags = 3'b111;
    for (int i = 0; i < 4; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      clrFlags = m;
      @(negedge clk);
      clrFlags = 0;
      expFlags = expFlags & ~m;
      check("R7 flag clear", 32'(statusFlags), 32'(expFlags));
    end

    // R2 pin glitch filter and stretch
    pinPulse(5);
    repeat (8) @(negedge clk);
    check("R2 5-sample low ignored", 32'(rstOut), 0);
    pinPulse(6);
    repeat (4) @(negedge clk);
    check("R2 6-sample low resets", 32'(rstOut), 1);
    check("R7 flags set by pin reset", 32'(statusFlags), 3'b111);
    clrFlags = 3'b111;
    @(negedge clk);
    check("R7 clear ignored in reset", 32'(statusFlags), 3'b111);
    clrFlags = 0;
    waitRelease(n);
    check("R2 release 18 cycles after pin high", 32'(n + 5), 18);
    check("R2 cause pin", 32'(causeCode), 0);
    check("R8 fetchStart at pin release", 32'(fetchStart), 1);
    pinPulse(30);
    check("R2 held while pin low", 32'(rstOut), 1);
    waitRelease(n);
    check("R2 long low release", 32'(n), 18);

    // R3/R4 watchdog with random scalers and service gaps
    for (int it = 0; it < 6; it++) begin
      int sc, lim;
      sc = (it < 4) ? it : int'($urandom_range(0, 3));
      lim = wdLimit(sc);
      @(negedge clk);
      wdScale = 2'(sc); wdEnable = 1; wdService = 1;
      @(negedge clk) wdService = 0;
      for (int k = 0; k < 3; k++) begin
        int gap;
        gap = int'($urandom_range(2, lim - 2));
        repeat (gap) @(negedge clk);
        check("R4 serviced watchdog quiet", 32'(rstOut), 0);
        wdService = 1;
        @(negedge clk) wdService = 0;
      end
      repeat (lim - 1) @(negedge clk);
      check("R3 no reset one cycle before timeout", 32'(rstOut), 0);
      @(negedge clk);
      check("R3 reset at timeout", 32'(rstOut), 1);
      wdEnable = 0;
      waitRelease(n);
      check("R3 cause watchdog", 32'(causeCode), 2);
      check("R3 vector watchdog", 32'(vecAddr), 32'(vecFor(2)));
      check("R8 fetchStart after watchdog", 32'(fetchStart), 1);
    end

    // R5 disabled watchdog
    begin
      bit sawRst;
      sawRst = 0;
      wdScale = 0;
      repeat (600) begin
        @(negedge clk);
        if (rstOut) sawRst = 1;
      end
      check("R5 disabled watchdog never resets", 32'(sawRst), 0);
    end

    // R6 clock monitor disabled: stopped clock ignored
    clkRun = 0;
    #300;
    check("R6 monitor off, stopped clock", 32'(rstOut), 0);
    clkRun = 1;
    repeat (20) @(negedge clk);
    check("R6 monitor off after restart", 32'(rstOut), 0);

    // R6 monitor enabled with clock running: no false reset
    cmEnable = 1;
    repeat (300) @(negedge clk);
    check("R6 no false clock fault", 32'(rstOut), 0);

    // R6 stop the bus clock
    clkRun = 0;
    #200;
    check("R6 reset without bus clock", 32'(rstOut), 1);
    clkRun = 1;
    @(negedge clk);
    waitRelease(n);
    check("R6 released after clock returns", 32'(rstOut), 0);
    check("R6 cause clock monitor", 32'(causeCode), 1);
    check("R6 vector clock monitor", 32'(vecAddr), 32'(vecFor(1)));
    check("R8 fetchStart after monitor", 32'(fetchStart), 1);
    check("R7 flags after monitor", 32'(statusFlags), 3'b111);
    cmEnable = 0;
    repeat (5) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule